// File: doc/BRIEF.md
# Ratiometric Gated Pulse Counter

This block measures the pulse stream of a clock-synchronized voltage-to-frequency converter. It counts the converter's active-low output pulses over a gate window whose length is a programmable number of cycles of the very clock that paces the converter. Because both the pulse rate and the gate come from one clock, any drift of that clock cancels, and the count depends only on the analog input. The full-scale count is half the gate length, so the measured input is twenty volts times the count over the gate length. That arithmetic belongs to software and is not part of this block.

The pulse input is asynchronous to the logic. It passes through a synchronizer, and each falling edge is counted once. When a gate closes, the count is latched onto the result port together with a one-cycle valid strobe. The accumulator restarts in the very next cycle, so consecutive windows tile time without a gap. Choosing a gate length that is a whole multiple of an interferer's period, such as mains hum, places a null of the response on that interferer.

Top module: `ratio_gate_counter`

## Requirements
- R1: While reset is asserted and right after it, `result_count` is 0 and `result_valid` is 0. No strobe appears before one full gate has elapsed.
- R2: `result_valid` pulses once per gate, and successive strobes are exactly M clock cycles apart, where M is the effective gate length.
- R3: `result_valid` is high for exactly one cycle per gate.
- R4: Each low pulse on `pulse_n` adds exactly one to the count, on its falling edge, however many cycles it stays low. A level held constantly high or constantly low gives a count of 0.
- R5: The count never exceeds floor(M/2). An odd M whose window would hold more falling edges saturates at that limit instead of wrapping.
- R6: There are no dead cycles between gates. With a pulse period P that divides M, every window, including consecutive ones, reports exactly M/P.
- R7: A `gate_ratio` value of 0 or 1 is treated as M = 2.
- R8: `gate_ratio` is sampled when a gate begins. A change made mid-gate leaves the running gate's length unchanged and takes effect from the next gate.
- R9: Between strobes, `result_count` holds the last latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_n | input | 1 | Active-low converter pulse, asynchronous |
| gate_ratio | input | DIV_W | Gate length M in clock cycles |
| result_count | output | DIV_W | Count N of the last completed gate |
| result_valid | output | 1 | One-cycle strobe when `result_count` updates |

## Verification
The assertions assume that a falling edge cannot be followed by another falling edge in the next cycle once the input is synchronized. They also assume that every gate is at least two cycles long, which makes the saturation bound and the one-cycle strobe meaningful. The stimulus produces periodic pulses whose low phase is at least one cycle and whose period is at least two cycles. It changes `gate_ratio` only at the falling clock edge. Before each measurement it discards the windows that straddle a change of period or ratio, so that the window count is fixed by the period alone.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

  // Effective gate length: values below two are raised to two.
  function automatic logic [31:0] eff_ratio(input logic [31:0] m);
    return (m < 32'd2) ? 32'd2 : m;
  endfunction

  // Largest legal count for a gate of the given length.
  function automatic logic [31:0] count_limit(input logic [31:0] m);
    return eff_ratio(m) >> 1;
  endfunction

endpackage

// File: rtl/rgc_pulse_sync.sv
module rgc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_n,
  output logic fall_evt
);
  // chain_q[0] is the newest sample; chain_q[STAGES-1] is the synchronized
  // level and chain_q[STAGES] is that level one cycle earlier.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], pulse_n};
  end

  assign fall_evt = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/rgc_gate_timer.sv
module rgc_gate_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             gate_open,
  output logic             gate_end,
  output logic [DIV_W-1:0] ratio_q
);
  logic             armed_q;
  logic [DIV_W-1:0] tick_q;
  logic [DIV_W-1:0] ratio_eff;

  assign ratio_eff = DIV_W'(rgc_pkg::eff_ratio(32'(ratio_in)));
  assign gate_open = armed_q;
  assign gate_end  = armed_q && (tick_q == (ratio_q - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tick_q  <= '0;
      ratio_q <= DIV_W'(2);
    end else if (!armed_q || gate_end) begin
      armed_q <= 1'b1;
      tick_q  <= '0;
      ratio_q <= ratio_eff;
    end else begin
      tick_q  <= tick_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/rgc_pulse_accum.sv
module rgc_pulse_accum #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             gate_end,
  input  logic [DIV_W-1:0] ratio_q,
  output logic [DIV_W-1:0] result_count,
  output logic             result_valid
);
  logic [DIV_W-1:0] acc_q;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] acc_next;

  assign limit    = DIV_W'(rgc_pkg::count_limit(32'(ratio_q)));
  assign acc_next = (count_en && (acc_q < limit)) ? acc_q + DIV_W'(1) : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      result_count <= '0;
      result_valid <= 1'b0;
    end else if (gate_end) begin
      result_count <= acc_next;
      result_valid <= 1'b1;
      acc_q        <= '0;
    end else begin
      result_valid <= 1'b0;
      acc_q        <= acc_next;
    end
  end
endmodule

// File: rtl/ratio_gate_counter.sv
module ratio_gate_counter #(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_n,
  input  logic [DIV_W-1:0] gate_ratio,
  output logic [DIV_W-1:0] result_count,
  output logic             result_valid
);
  logic             fall_evt;
  logic             gate_open;
  logic             gate_end;
  logic             count_en;
  logic [DIV_W-1:0] ratio_q;

  rgc_pulse_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pulse_n(pulse_n), .fall_evt(fall_evt)
  );

  rgc_gate_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .ratio_in(gate_ratio),
    .gate_open(gate_open), .gate_end(gate_end), .ratio_q(ratio_q)
  );

  assign count_en = fall_evt & gate_open;

  rgc_pulse_accum #(.DIV_W(DIV_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .gate_end(gate_end),
    .ratio_q(ratio_q), .result_count(result_count), .result_valid(result_valid)
  );
endmodule

// File: rtl/ratio_gate_counter_chk.sv
module ratio_gate_counter_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_end,
  input logic             fall_evt,
  input logic [DIV_W-1:0] result_count,
  input logic             result_valid
);
  logic [31:0] len_q;
  logic [31:0] last_len_q;
  logic [1:0]  seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= 32'd0;
      last_len_q <= 32'd0;
      seen_q     <= 2'd0;
    end else if (gate_end) begin
      len_q      <= 32'd1;
      last_len_q <= len_q;
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end else begin
      len_q <= len_q + 32'd1;
    end
  end

  AST_VALID_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> result_valid);  // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);  // R3
  AST_FALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && seen_q == 2'd2) |-> (32'(result_count) <= (last_len_q >> 1)));  // R5
  AST_MIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end && seen_q != 2'd0) |-> (len_q >= 32'd2));  // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result_count));  // R9
endmodule

bind ratio_gate_counter ratio_gate_counter_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_end(gate_end), .fall_evt(fall_evt),
  .result_count(result_count), .result_valid(result_valid)
);

// File: tb/ratio_gate_counter_tb_top.sv
module ratio_gate_counter_tb_top;
  localparam int DIV_W = 16;
  localparam int NV = 8;
  localparam int VM [NV] = '{20, 20, 24, 30, 100, 7, 4000, 60};
  localparam int VP [NV] = '{ 4,  5,  2,  3,  10, 7,    8,  6};
  localparam int VL [NV] = '{ 1,  3,  1,  1,   4, 1,    2,  5};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_n = 1'b1;
  logic [DIV_W-1:0] gate_ratio = DIV_W'(20);
  logic [DIV_W-1:0] result_count;
  logic             result_valid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_strobe = 0;
  int gen_per = 0;
  int gen_low = 1;
  logic gen_level = 1'b1;
  int ph = 0;

  always #5 clk = ~clk;

  ratio_gate_counter #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_n(pulse_n), .gate_ratio(gate_ratio),
    .result_count(result_count), .result_valid(result_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Periodic pulse source, updated away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (gen_per == 0) pulse_n = gen_level;
      else begin
        ph = (ph + 1 >= gen_per) ? 0 : ph + 1;
        pulse_n = (ph < gen_low) ? 1'b0 : 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic next_strobe(output int gap);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid && n < 20000);
    if (!result_valid) check(1'b0, "R2 strobe missing", 0, 1);
    gap = cyc - last_strobe;
    last_strobe = cyc;
  endtask

  task automatic settle(input int k);
    int g;
    for (int i = 0; i < k; i++) next_strobe(g);
  endtask

  task automatic set_stim(input int m, input int p, input int l);
    @(negedge clk);
    gate_ratio = DIV_W'(m);
    gen_per = p;
    gen_low = l;
  endtask

  initial begin
    int gap;
    int held;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(result_count == '0, "R1 count in reset", int'(result_count), 0);
    check(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (result_valid) check(1'b0, "R1 early strobe", i, -1);
    end
    check(result_count == '0, "R1 count after reset", int'(result_count), 0);
    next_strobe(gap);

    // Table walk: R2 gate spacing, R4 counting, R6 gapless windows
    for (int i = 0; i < NV; i++) begin
      set_stim(VM[i], VP[i], VL[i]);
      settle(3);
      next_strobe(gap);
      check(gap == VM[i], "R2 strobe spacing", gap, VM[i]);
      check(int'(result_count) == VM[i] / VP[i], "R4 count", int'(result_count), VM[i] / VP[i]);
      @(negedge clk);
      check(result_valid == 1'b0, "R3 strobe width", int'(result_valid), 0);
      next_strobe(gap);
      check(int'(result_count) == VM[i] / VP[i], "R6 next window", int'(result_count), VM[i] / VP[i]);
    end

    // R9: value holds mid-window
    set_stim(30, 3, 1);
    settle(3);
    held = int'(result_count);
    repeat (15) @(negedge clk);
    check(int'(result_count) == held && held == 10, "R9 hold", int'(result_count), 10);

    // R5: odd gate with full-rate pulses saturates
    set_stim(5, 2, 1);
    settle(3);
    next_strobe(gap);
    check(int'(result_count) == 2, "R5 saturate M=5", int'(result_count), 2);
    next_strobe(gap);
    check(int'(result_count) == 2, "R5 saturate M=5 next", int'(result_count), 2);
    set_stim(9, 2, 1);
    settle(3);
    next_strobe(gap);
    check(int'(result_count) == 4, "R5 saturate M=9", int'(result_count), 4);

    // R7: ratios 1 and 0 act as 2
    set_stim(1, 2, 1);
    settle(3);
    next_strobe(gap);
    check(gap == 2, "R7 spacing M=1", gap, 2);
    check(int'(result_count) == 1, "R7 count M=1", int'(result_count), 1);
    set_stim(0, 2, 1);
    settle(3);
    next_strobe(gap);
    check(gap == 2, "R7 spacing M=0", gap, 2);
    check(int'(result_count) == 1, "R7 count M=0", int'(result_count), 1);

    // R4: steady levels produce no counts
    @(negedge clk);
    gate_ratio = DIV_W'(16);
    gen_per = 0;
    gen_level = 1'b0;
    settle(3);
    next_strobe(gap);
    check(int'(result_count) == 0, "R4 steady low", int'(result_count), 0);
    @(negedge clk);
    gen_level = 1'b1;
    settle(3);
    next_strobe(gap);
    check(int'(result_count) == 0, "R4 steady high", int'(result_count), 0);

    // R8: change of ratio mid-gate
    set_stim(20, 4, 1);
    settle(3);
    repeat (5) @(negedge clk);
    gate_ratio = DIV_W'(40);
    next_strobe(gap);
    check(gap == 20, "R8 running gate kept", gap, 20);
    next_strobe(gap);
    check(gap == 40, "R8 new gate length", gap, 40);
    check(int'(result_count) == 10, "R8 new gate count", int'(result_count), 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule